// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block times programmed-I/O transfers on a parallel ATA channel that carries two devices. A request names the target device, says whether it is a read or a write, and carries the write word. The block then runs three phases, all counted in local clocks. First comes address setup. Next is the active phase, where the read or write strobe is driven low. Last is recovery, where the strobe is high again. A one-clock done pulse closes the cycle.

Each device has its own timing byte for reads and its own timing byte for writes. A timing byte holds an active count and a recovery count. The address-setup count is a single value shared by the whole channel. System software therefore sets it to suit the slower of the two devices, while the strobe and recovery widths still follow each device.

The timing bytes and the shared control byte arrive on input ports. They are copied into internal timing registers on a load pulse. Reset fills those registers with the slowest possible timing, so a channel that was never programmed still works safely.

Top module: `ata_pio_timer`

## Requirements
- R1: An accepted cycle runs setup clocks with both strobes high, then active clocks with one strobe low, then recovery clocks with both strobes high, then one clock of `done` high. `done` is high for exactly one clock per cycle.
- R2: A count field of 0 gives 1 clock. Any other value n gives n clocks.
- R3: The active count is taken from bits 7:4 of a timing byte and the recovery count from bits 3:0. The byte used is picked by the request: device 0 or 1, read or write.
- R4: The setup count comes from bits 5:4 of `chan_ctl` and is the same for both devices and both directions. The other bits of `chan_ctl` have no effect.
- R5: `rd_data` takes `ata_din` as sampled on the last active clock of a read. It keeps that value through later write cycles and until the next read finishes.
- R6: A request is accepted only while the block is idle. `busy` is high from the clock after acceptance through the last recovery clock. A request raised while busy has no effect.
- R7: After reset the strobes are high, `busy` and `done` are low, and `rd_data` is 0. The timing registers hold the slowest timing: setup 3, active 15, recovery 15.
- R8: A strobe goes low only inside an accepted cycle. `dior_n` is used only for reads and `diow_n` only for writes, never both at once. During a write, `dout_en` is high and `ata_dout` equals the request word.
- R9: `tim_load` copies the timing inputs only while the block is idle. A load pulse during a cycle has no effect on the timing registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tim_load | input | 1 | Copy the timing inputs into the timing registers when idle |
| rd_tim0 | input | 8 | Device 0 read timing: active 7:4, recovery 3:0 |
| wr_tim0 | input | 8 | Device 0 write timing |
| rd_tim1 | input | 8 | Device 1 read timing |
| wr_tim1 | input | 8 | Device 1 write timing |
| chan_ctl | input | 8 | Channel control; setup count in bits 5:4 |
| req_valid | input | 1 | Transfer request |
| req_dev | input | 1 | Target device (0 or 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Word to write |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| dev_sel | output | 1 | Device of the current or last cycle |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dout_en | output | 1 | Data bus drive enable during a write |
| ata_dout | output | 16 | Data bus output |
| ata_din | input | 16 | Data bus input |
| rd_data | output | 16 | Last captured read word |

## Verification
The bench programs four timing bytes with distinct active and recovery values. It then runs every combination of device and direction. A swapped byte, device or nibble therefore shows up as a wrong phase length. Further vectors use zero fields, the maximum fields and `chan_ctl` values with stray bits set, to separate the minimum-one rule and the field position from plain pass-through. During each read, `ata_din` carries the expected word only on the last active clock and its inverse on every other clock, so an off-by-one capture is caught. Directed tests then check the reset timing, and that a request or a timing load raised during a busy cycle is ignored.

// File: rtl/ata_pio_timer.sv
module ata_pio_timer #(
  parameter int DW = 16,
  parameter int CW = 4,
  parameter int SW = 2,
  parameter int SETUP_LSB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tim_load,
  input  logic [2*CW-1:0] rd_tim0,
  input  logic [2*CW-1:0] wr_tim0,
  input  logic [2*CW-1:0] rd_tim1,
  input  logic [2*CW-1:0] wr_tim1,
  input  logic [7:0]    chan_ctl,
  input  logic          req_valid,
  input  logic          req_dev,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic          dev_sel,
  output logic          dior_n,
  output logic          diow_n,
  output logic          dout_en,
  output logic [DW-1:0] ata_dout,
  input  logic [DW-1:0] ata_din,
  output logic [DW-1:0] rd_data
);
  localparam int TW = 2 * CW;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACT, ST_REC} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tim_q [2][2];
  logic [SW-1:0] setup_q;
  logic [CW-1:0] act_q, rec_q;
  logic          wr_q, dev_q;
  logic [DW-1:0] wdata_q, rd_q;
  logic [TW-1:0] sel_tim;

  function automatic logic [CW-1:0] span(input logic [CW-1:0] v);
    return (v == '0) ? CW'(0) : v - CW'(1);
  endfunction

  wire idle   = (state == ST_IDLE);
  wire accept = idle && req_valid;
  wire last   = (cnt == '0);

  assign sel_tim  = tim_q[req_dev][req_write];
  assign busy     = !idle;
  assign dior_n   = !(state == ST_ACT && !wr_q);
  assign diow_n   = !(state == ST_ACT && wr_q);
  assign dout_en  = busy && wr_q;
  assign ata_dout = wdata_q;
  assign dev_sel  = dev_q;
  assign rd_data  = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < 2; d++)
        for (int w = 0; w < 2; w++)
          tim_q[d][w] <= '1;
      setup_q <= '1;
    end else if (tim_load && idle) begin
      tim_q[0][0] <= rd_tim0;
      tim_q[0][1] <= wr_tim0;
      tim_q[1][0] <= rd_tim1;
      tim_q[1][1] <= wr_tim1;
      setup_q     <= chan_ctl[SETUP_LSB +: SW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      act_q   <= '0;
      rec_q   <= '0;
      wr_q    <= 1'b0;
      dev_q   <= 1'b0;
      wdata_q <= '0;
      rd_q    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_SETUP;
          cnt     <= span(CW'(setup_q));
          act_q   <= sel_tim[TW-1:CW];
          rec_q   <= sel_tim[CW-1:0];
          wr_q    <= req_write;
          dev_q   <= req_dev;
          wdata_q <= req_wdata;
        end
        ST_SETUP: if (last) begin
          state <= ST_ACT;
          cnt   <= span(act_q);
        end else cnt <= cnt - CW'(1);
        ST_ACT: if (last) begin
          state <= ST_REC;
          cnt   <= span(rec_q);
          if (!wr_q) rd_q <= ata_din;
        end else cnt <= cnt - CW'(1);
        ST_REC: if (last) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else cnt <= cnt - CW'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

module ata_pio_timer_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          busy,
  input logic          done,
  input logic          dior_n,
  input logic          diow_n,
  input logic          dout_en,
  input logic [DW-1:0] rd_data
);
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n));
  assert_strobe_in_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dior_n || !diow_n) |-> busy);
  assert_write_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !diow_n |-> dout_en);
  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_accept_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dior_n) |-> $stable(rd_data));
endmodule

bind ata_pio_timer ata_pio_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .dior_n(dior_n), .diow_n(diow_n), .dout_en(dout_en), .rd_data(rd_data)
);

// File: tb/test_ata_pio_timer.sv
module test_ata_pio_timer;
  logic clk = 1'b0, rst_n = 1'b0, tim_load = 1'b0;
  logic [7:0] rd_tim0 = '0, wr_tim0 = '0, rd_tim1 = '0, wr_tim1 = '0, chan_ctl = '0;
  logic req_valid = 1'b0, req_dev = 1'b0, req_write = 1'b0;
  logic [15:0] req_wdata = '0, ata_din = '0;
  logic busy, done, dev_sel, dior_n, diow_n, dout_en;
  logic [15:0] ata_dout, rd_data;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  ata_pio_timer i_ata_pio_timer (
    .clk(clk), .rst_n(rst_n), .tim_load(tim_load),
    .rd_tim0(rd_tim0), .wr_tim0(wr_tim0), .rd_tim1(rd_tim1), .wr_tim1(wr_tim1),
    .chan_ctl(chan_ctl), .req_valid(req_valid), .req_dev(req_dev),
    .req_write(req_write), .req_wdata(req_wdata), .busy(busy), .done(done),
    .dev_sel(dev_sel), .dior_n(dior_n), .diow_n(diow_n), .dout_en(dout_en),
    .ata_dout(ata_dout), .ata_din(ata_din), .rd_data(rd_data)
  );

  // {chan_ctl, rd0, wr0, rd1, wr1, 6'b0, dev, write}
  localparam logic [47:0] VEC [8] = '{
    {8'h10, 8'h21, 8'h43, 8'h65, 8'h87, 8'h00},
    {8'h10, 8'h21, 8'h43, 8'h65, 8'h87, 8'h01},
    {8'h10, 8'h21, 8'h43, 8'h65, 8'h87, 8'h02},
    {8'h10, 8'h21, 8'h43, 8'h65, 8'h87, 8'h03},
    {8'h30, 8'h00, 8'h11, 8'h11, 8'h11, 8'h00},
    {8'h00, 8'h11, 8'h11, 8'h11, 8'hF0, 8'h03},
    {8'h2F, 8'h11, 8'h11, 8'h0F, 8'h11, 8'h02},
    {8'hC1, 8'h11, 8'h3A, 8'h11, 8'h11, 8'h01}
  };

  function automatic int cl(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] c, r0, w0, r1, w1);
    @(negedge clk);
    chan_ctl = c; rd_tim0 = r0; wr_tim0 = w0; rd_tim1 = r1; wr_tim1 = w1;
    tim_load = 1'b1;
    @(negedge clk);
    tim_load = 1'b0;
  endtask

  task automatic run_cycle(input logic d, input logic w, input logic [15:0] wd,
                           input logic [15:0] dv, input int exp_a,
                           output int s, output int a, output int r,
                           output bit bad_strobe, output bit bad_dout);
    int ph;
    s = 0; a = 0; r = 0; ph = 0; bad_strobe = 0; bad_dout = 0;
    @(negedge clk);
    req_valid = 1'b1; req_dev = d; req_write = w; req_wdata = wd; ata_din = ~dv;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 200; n++) begin
      if (done) break;
      if (w ? !dior_n : !diow_n) bad_strobe = 1;
      if (w ? !diow_n : !dior_n) begin
        a++; ph = 1;
        if (w && (!dout_en || ata_dout != wd)) bad_dout = 1;
        ata_din = (a == exp_a) ? dv : ~dv;
      end else begin
        if (ph == 0) s++; else r++;
        ata_din = ~dv;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s, a, r, es, ea, er, nb;
    bit bs, bd;
    logic [15:0] last_rd, dv;
    logic [7:0] tb;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R7 busy/done at reset", busy, 0);
    chk(dior_n === 1'b1 && diow_n === 1'b1, "R7 strobes at reset", {dior_n, diow_n}, 3);
    chk(rd_data === 16'h0, "R7 rd_data at reset", rd_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy === 1'b0 && dior_n === 1'b1 && diow_n === 1'b1, "R8 no strobe without request", busy, 0);
    run_cycle(1'b1, 1'b0, 16'h0, 16'hBEEF, 15, s, a, r, bs, bd);
    chk(s == 3, "R7 reset setup", s, 3);
    chk(a == 15, "R7 reset active", a, 15);
    chk(r == 15, "R7 reset recovery", r, 15);
    chk(rd_data == 16'hBEEF, "R5 reset-timing read", rd_data, 16'hBEEF);
    last_rd = 16'hBEEF;

    for (int i = 0; i < 8; i++) begin
      load(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8]);
      tb = VEC[i][1] ? (VEC[i][0] ? VEC[i][15:8] : VEC[i][23:16])
                     : (VEC[i][0] ? VEC[i][31:24] : VEC[i][39:32]);
      es = cl(int'(VEC[i][45:44]));
      ea = cl(int'(tb[7:4]));
      er = cl(int'(tb[3:0]));
      dv = 16'h1000 + 16'(i) * 16'h0111;
      run_cycle(VEC[i][1], VEC[i][0], ~dv, dv, ea, s, a, r, bs, bd);
      chk(s == es, $sformatf("R4 setup vec%0d", i), s, es);
      chk(a == ea, $sformatf("R3 R2 active vec%0d", i), a, ea);
      chk(r == er, $sformatf("R3 R2 recovery vec%0d", i), r, er);
      chk(!bs, $sformatf("R8 strobe direction vec%0d", i), bs, 0);
      chk(dev_sel == VEC[i][1], $sformatf("R3 device select vec%0d", i), dev_sel, VEC[i][1]);
      if (VEC[i][0]) begin
        chk(!bd, $sformatf("R8 write data vec%0d", i), bd, 0);
        chk(rd_data == last_rd, $sformatf("R5 held over write vec%0d", i), rd_data, last_rd);
      end else begin
        chk(rd_data == dv, $sformatf("R5 capture vec%0d", i), rd_data, dv);
        last_rd = dv;
      end
      chk(done && !busy, $sformatf("R1 done pulse vec%0d", i), done, 1);
      @(negedge clk);
      chk(!done, $sformatf("R1 done single vec%0d", i), done, 0);
    end

    // R6 R9: request and timing load raised during a busy cycle
    load(8'h10, 8'h22, 8'h11, 8'h11, 8'h11);
    @(negedge clk);
    req_valid = 1'b1; req_dev = 1'b0; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1;
    chan_ctl = 8'h30; rd_tim0 = 8'hFF; tim_load = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; tim_load = 1'b0;
    chan_ctl = 8'h00; rd_tim0 = 8'h00;
    nb = 0;
    for (int n = 0; n < 100 && !done; n++) begin
      @(negedge clk);
    end
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (busy || !dior_n || !diow_n) nb++;
    end
    chk(nb == 0, "R6 request during busy ignored", nb, 0);
    run_cycle(1'b0, 1'b0, 16'h0, 16'h5A5A, 2, s, a, r, bs, bd);
    chk(s == 1 && a == 2 && r == 2, "R9 load during busy ignored", s * 100 + a * 10 + r, 122);
    chk(rd_data == 16'h5A5A, "R5 capture after ignore", rd_data, 16'h5A5A);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule